// File: doc/BRIEF.md
# PIO Timing Count Calculator

This block turns the nanosecond timing of one programmed-I/O transfer mode into the clock counts that a disk controller channel is programmed with. The caller supplies the mode's address setup time, strobe active time and total cycle time, along with the period of the bus clock in nanoseconds. The block produces three counts: setup, active and recovery. Each conversion rounds up to whole clocks. The block then applies the controller's lower and upper limits and a correction that depends on the silicon revision.

The two drives on the secondary channel share one set of timing registers. When the target drive sits on that channel and its partner drive is present, each output count is the larger of the drive's own value and the partner's value. This keeps both drives within their timing.

A request starts on a one-cycle `start` pulse. All four ceiling divisions run one after another through a single shared restoring divider. The result appears on registered outputs together with a one-cycle `done` pulse, and the outputs hold until the next result.

Top module: `pio_timing_calc`

## Requirements
- R1: Each count is a ceiling division of a time by the clock period. With no merge taking place, `setup_cnt` equals ceil(`setup_ns` / `clk_ns`).
- R2: A clock period input of 0 is treated as a period of 1 ns.
- R3: The recovery time is `cycle_ns − setup_ns − active_ns`, taken as 0 when negative. The recovery count is the larger of two values: the ceiling of the recovery time over the clock period, and ceil(`cycle_ns`/clk) − setup count − active count (taken as 0 when negative). The active count used here has already been raised to its minimum.
- R4: The active and recovery counts are each raised to at least 2 before any fold or revision correction.
- R5: If the recovery count exceeds 17, the excess is added to the active count and recovery becomes 17. The active count is then capped at 16.
- R6: When `rev` is 2 or above, 1 is subtracted from the recovery count. The recovery count is then capped at 16 for every revision.
- R7: When `drive_sel` is 2 or 3 (bit 1 set) and `partner_on` is 1, each output is the maximum of the drive's own count and the matching partner count. In every other case the partner inputs have no effect.
- R8: `done` is high for exactly one cycle per accepted request. The three count outputs change only in that cycle and hold their values until the next `done`.
- R9: `busy` rises the cycle after an accepted `start`. A `start` raised while `busy` is high is ignored and produces no extra result.
- R10: After reset, `busy`, `done` and all count outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; inputs are captured in this cycle |
| setup_ns | input | TW | Address setup time in ns |
| active_ns | input | TW | Strobe active time in ns |
| cycle_ns | input | TW | Total cycle time in ns |
| clk_ns | input | CW | Bus clock period in ns (0 is treated as 1) |
| rev | input | RW | Controller silicon revision |
| drive_sel | input | 2 | Drive index 0..3; 2 and 3 are on the secondary channel |
| partner_on | input | 1 | The partner drive on the same channel is present |
| partner_setup | input | TW | Partner's setup count |
| partner_active | input | CNTW | Partner's active count |
| partner_recov | input | CNTW | Partner's recovery count |
| busy | output | 1 | A calculation is in progress |
| done | output | 1 | One-cycle result-valid pulse |
| setup_cnt | output | TW | Setup count |
| active_cnt | output | CNTW | Active count (2..16) |
| recov_cnt | output | CNTW | Recovery count (1..16) |

## Verification
The bench builds the block with its default widths: 10-bit times, an 8-bit clock period and a 2-bit revision. These widths allow cycle times close to 1 µs against clock periods down to 1 ns, which gives raw recovery counts far above 17. The fold into the active phase and the active cap at 16 are therefore exercised alongside the ordinary short-mode cases. The widths also allow a setup plus active time longer than the whole cycle, so the negative-remainder clamps in R3 are reachable. The 2-bit revision covers both sides of the revision correction, and the full drive index range reaches both the merge and the non-merge paths of R7.

// File: rtl/pio_cnt_pkg.sv
package pio_cnt_pkg;
  // Controller limits on the encoded counts
  localparam int ACT_MIN  = 2;
  localparam int REC_MIN  = 2;
  localparam int REC_FOLD = 17;
  localparam int ACT_MAX  = 16;
  localparam int REC_MAX  = 16;
  localparam int REV_ADJ  = 2;
  localparam int CNTW     = $clog2(REC_FOLD + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_FIN  = 2'd2
  } calc_state_t;

  // Order in which the four conversions pass through the divider
  typedef enum logic [1:0] {
    SL_SETUP  = 2'd0,
    SL_ACTIVE = 2'd1,
    SL_CYCLE  = 2'd2,
    SL_RTIME  = 2'd3
  } conv_sel_t;
endpackage

// File: rtl/pio_ceil_div.sv
// Restoring long divider producing ceil(num / den), one quotient bit per cycle.
module pio_ceil_div #(
  parameter int NW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          fin,
  output logic [NW-1:0] ceil_q
);
  localparam int RW2 = NW + 1;
  localparam int KW  = $clog2(NW + 1);

  logic [RW2-1:0] rem_q;
  logic [NW-1:0]  quo_q;
  logic [DW-1:0]  den_q;
  logic [KW-1:0]  left_q;
  logic           run_q;

  logic [RW2-1:0] rem_sh;
  logic [RW2-1:0] den_ext;
  logic           fits;

  always_comb begin
    rem_sh  = {rem_q[NW-1:0], quo_q[NW-1]};
    den_ext = RW2'(den_q);
    fits    = (rem_sh >= den_ext);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      den_q  <= '0;
      left_q <= '0;
      run_q  <= 1'b0;
      fin    <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        rem_q  <= '0;
        quo_q  <= num;
        den_q  <= (den == '0) ? DW'(1) : den;
        left_q <= KW'(NW);
        run_q  <= 1'b1;
      end else if (run_q) begin
        rem_q  <= fits ? (rem_sh - den_ext) : rem_sh;
        quo_q  <= {quo_q[NW-2:0], fits};
        left_q <= left_q - 1'b1;
        if (left_q == KW'(1)) begin
          run_q <= 1'b0;
          fin   <= 1'b1;
        end
      end
    end
  end

  assign ceil_q = quo_q + NW'(rem_q != '0);
endmodule

// File: rtl/pio_cnt_limit.sv
// Recovery derivation, minimums, fold of excess recovery, caps, revision fix.
module pio_cnt_limit
  import pio_cnt_pkg::*;
#(
  parameter int TW = 10,
  parameter int RW = 2
) (
  input  logic [TW-1:0]   set_q,
  input  logic [TW-1:0]   act_q,
  input  logic [TW-1:0]   cyc_q,
  input  logic [TW-1:0]   rtm_q,
  input  logic [RW-1:0]   rev,
  output logic [CNTW-1:0] act_o,
  output logic [CNTW-1:0] rec_o
);
  localparam int XW = TW + 3;
  localparam logic signed [XW-1:0] K_ACT_MIN  = XW'(ACT_MIN);
  localparam logic signed [XW-1:0] K_REC_MIN  = XW'(REC_MIN);
  localparam logic signed [XW-1:0] K_REC_FOLD = XW'(REC_FOLD);
  localparam logic signed [XW-1:0] K_ACT_MAX  = XW'(ACT_MAX);
  localparam logic signed [XW-1:0] K_REC_MAX  = XW'(REC_MAX);
  localparam logic signed [XW-1:0] K_ONE      = XW'(1);
  localparam logic [RW-1:0]        K_REV_ADJ  = RW'(REV_ADJ);

  logic signed [XW-1:0] ac, rc, left_over;

  always_comb begin
    ac = XW'(act_q);
    if (ac < K_ACT_MIN) ac = K_ACT_MIN;
    left_over = XW'(cyc_q) - XW'(set_q) - ac;
    rc = XW'(rtm_q);
    if (left_over > rc) rc = left_over;
    if (rc < K_REC_MIN) rc = K_REC_MIN;
    if (rc > K_REC_FOLD) begin
      ac = ac + (rc - K_REC_FOLD);
      rc = K_REC_FOLD;
    end
    if (ac > K_ACT_MAX) ac = K_ACT_MAX;
    if (rev >= K_REV_ADJ) rc = rc - K_ONE;
    if (rc > K_REC_MAX) rc = K_REC_MAX;
    act_o = ac[CNTW-1:0];
    rec_o = rc[CNTW-1:0];
  end
endmodule

// File: rtl/pio_pair_merge.sv
// Per-field slower-of-two merge for a shared-register channel.
module pio_pair_merge #(
  parameter int W = 5
) (
  input  logic         sel_pair,
  input  logic [W-1:0] own,
  input  logic [W-1:0] mate,
  output logic [W-1:0] merged
);
  always_comb begin
    merged = own;
    if (sel_pair && (mate > own)) merged = mate;
  end
endmodule

// File: rtl/pio_timing_calc.sv
module pio_timing_calc
  import pio_cnt_pkg::*;
#(
  parameter int TW = 10,
  parameter int CW = 8,
  parameter int RW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [TW-1:0]   setup_ns,
  input  logic [TW-1:0]   active_ns,
  input  logic [TW-1:0]   cycle_ns,
  input  logic [CW-1:0]   clk_ns,
  input  logic [RW-1:0]   rev,
  input  logic [1:0]      drive_sel,
  input  logic            partner_on,
  input  logic [TW-1:0]   partner_setup,
  input  logic [CNTW-1:0] partner_active,
  input  logic [CNTW-1:0] partner_recov,
  output logic            busy,
  output logic            done,
  output logic [TW-1:0]   setup_cnt,
  output logic [CNTW-1:0] active_cnt,
  output logic [CNTW-1:0] recov_cnt
);
  localparam int NCONV = 4;
  localparam int SW    = TW + 2;

  calc_state_t state_q;
  conv_sel_t   sel_q;

  // Captured request
  logic [TW-1:0]   set_ns_q, act_ns_q, cyc_ns_q, rtm_ns_q;
  logic [CW-1:0]   per_q;
  logic [RW-1:0]   rev_q;
  logic            pair_q;
  logic [TW-1:0]   p_set_q;
  logic [CNTW-1:0] p_act_q, p_rec_q;

  // Conversion results, indexed by conv_sel_t
  logic [TW-1:0] conv_q [NCONV];

  logic          div_go;
  logic          div_fin;
  logic [TW-1:0] div_num;
  logic [TW-1:0] div_res;

  logic signed [SW-1:0] rtm_raw;
  logic [TW-1:0]        rtm_clamp;

  always_comb begin
    rtm_raw   = SW'(cycle_ns) - SW'(setup_ns) - SW'(active_ns);
    rtm_clamp = rtm_raw[SW-1] ? '0 : rtm_raw[TW-1:0];
  end

  always_comb begin
    unique case (sel_q)
      SL_SETUP:  div_num = set_ns_q;
      SL_ACTIVE: div_num = act_ns_q;
      SL_CYCLE:  div_num = cyc_ns_q;
      default:   div_num = rtm_ns_q;
    endcase
  end

  pio_ceil_div #(.NW(TW), .DW(CW)) u_div (
    .clk    (clk),
    .rst    (rst),
    .go     (div_go),
    .num    (div_num),
    .den    (per_q),
    .fin    (div_fin),
    .ceil_q (div_res)
  );

  logic [CNTW-1:0] lim_act, lim_rec;

  pio_cnt_limit #(.TW(TW), .RW(RW)) u_limit (
    .set_q (conv_q[SL_SETUP]),
    .act_q (conv_q[SL_ACTIVE]),
    .cyc_q (conv_q[SL_CYCLE]),
    .rtm_q (conv_q[SL_RTIME]),
    .rev   (rev_q),
    .act_o (lim_act),
    .rec_o (lim_rec)
  );

  logic [TW-1:0]   mrg_set;
  logic [CNTW-1:0] mrg_act, mrg_rec;

  pio_pair_merge #(.W(TW)) u_mrg_set (
    .sel_pair (pair_q), .own (conv_q[SL_SETUP]), .mate (p_set_q), .merged (mrg_set)
  );
  pio_pair_merge #(.W(CNTW)) u_mrg_act (
    .sel_pair (pair_q), .own (lim_act), .mate (p_act_q), .merged (mrg_act)
  );
  pio_pair_merge #(.W(CNTW)) u_mrg_rec (
    .sel_pair (pair_q), .own (lim_rec), .mate (p_rec_q), .merged (mrg_rec)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      sel_q     <= SL_SETUP;
      div_go    <= 1'b0;
      done      <= 1'b0;
      setup_cnt <= '0;
      active_cnt<= '0;
      recov_cnt <= '0;
      set_ns_q  <= '0;
      act_ns_q  <= '0;
      cyc_ns_q  <= '0;
      rtm_ns_q  <= '0;
      per_q     <= '0;
      rev_q     <= '0;
      pair_q    <= 1'b0;
      p_set_q   <= '0;
      p_act_q   <= '0;
      p_rec_q   <= '0;
      for (int i = 0; i < NCONV; i++) conv_q[i] <= '0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            set_ns_q <= setup_ns;
            act_ns_q <= active_ns;
            cyc_ns_q <= cycle_ns;
            rtm_ns_q <= rtm_clamp;
            per_q    <= clk_ns;
            rev_q    <= rev;
            pair_q   <= drive_sel[1] & partner_on;
            p_set_q  <= partner_setup;
            p_act_q  <= partner_active;
            p_rec_q  <= partner_recov;
            sel_q    <= SL_SETUP;
            div_go   <= 1'b1;
            state_q  <= ST_CONV;
          end
        end
        ST_CONV: begin
          if (div_fin) begin
            conv_q[sel_q] <= div_res;
            if (sel_q == SL_RTIME) begin
              state_q <= ST_FIN;
            end else begin
              sel_q  <= conv_sel_t'(sel_q + 2'd1);
              div_go <= 1'b1;
            end
          end
        end
        default: begin
          setup_cnt  <= mrg_set;
          active_cnt <= mrg_act;
          recov_cnt  <= mrg_rec;
          done       <= 1'b1;
          state_q    <= ST_IDLE;
        end
      endcase
    end
  end

  assign busy = (state_q != ST_IDLE);
endmodule

// File: rtl/pio_timing_calc_chk.sv
module pio_timing_calc_chk
  import pio_cnt_pkg::*;
#(
  parameter int TW = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            busy,
  input logic            done,
  input logic [TW-1:0]   setup_cnt,
  input logic [CNTW-1:0] active_cnt,
  input logic [CNTW-1:0] recov_cnt
);
  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(setup_cnt) && $stable(active_cnt) && $stable(recov_cnt)));

  // R5
  active_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (active_cnt >= CNTW'(ACT_MIN) && active_cnt <= CNTW'(ACT_MAX)));

  // R6
  recov_bound_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (recov_cnt >= CNTW'(1) && recov_cnt <= CNTW'(REC_MAX)));

  // R9
  busy_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

bind pio_timing_calc pio_timing_calc_chk #(.TW(TW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .setup_cnt  (setup_cnt),
  .active_cnt (active_cnt),
  .recov_cnt  (recov_cnt)
);

// File: tb/pio_timing_calc_tb.sv
module pio_timing_calc_tb;
  import pio_cnt_pkg::*;
  localparam int TW = 10;
  localparam int CW = 8;
  localparam int RW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [TW-1:0] setup_ns = '0, active_ns = '0, cycle_ns = '0;
  logic [CW-1:0] clk_ns = '0;
  logic [RW-1:0] rev = '0;
  logic [1:0] drive_sel = '0;
  logic partner_on = 1'b0;
  logic [TW-1:0] partner_setup = '0;
  logic [CNTW-1:0] partner_active = '0, partner_recov = '0;
  logic busy, done;
  logic [TW-1:0] setup_cnt;
  logic [CNTW-1:0] active_cnt, recov_cnt;

  always #5 clk = ~clk;

  pio_timing_calc #(.TW(TW), .CW(CW), .RW(RW)) u_dut (
    .clk (clk), .rst (rst), .start (start),
    .setup_ns (setup_ns), .active_ns (active_ns), .cycle_ns (cycle_ns),
    .clk_ns (clk_ns), .rev (rev), .drive_sel (drive_sel),
    .partner_on (partner_on), .partner_setup (partner_setup),
    .partner_active (partner_active), .partner_recov (partner_recov),
    .busy (busy), .done (done), .setup_cnt (setup_cnt),
    .active_cnt (active_cnt), .recov_cnt (recov_cnt)
  );

  typedef struct {
    int    s;
    int    a;
    int    r;
    string tag;
  } exp_t;

  exp_t  sb[$];
  exp_t  last_exp;
  int    n_chk = 0;
  int    n_bad = 0;
  bit    ended = 0;

  function automatic int cdiv(int x, int p);
    return (x + p - 1) / p;
  endfunction

  function automatic exp_t model(int s, int a, int c, int p, int rv, int drv,
                                 int pon, int ps, int pa, int pr, string tag);
    exp_t e;
    int per, sc, ac, cc, rt, rc, r2;
    per = (p == 0) ? 1 : p;
    sc = cdiv(s, per);
    ac = cdiv(a, per);
    if (ac < 2) ac = 2;
    cc = cdiv(c, per);
    rt = c - s - a;
    if (rt < 0) rt = 0;
    rc = cdiv(rt, per);
    r2 = cc - sc - ac;
    if (r2 > rc) rc = r2;
    if (rc < 2) rc = 2;
    if (rc > 17) begin ac = ac + rc - 17; rc = 17; end
    if (ac > 16) ac = 16;
    if (rv >= 2) rc = rc - 1;
    if (rc > 16) rc = 16;
    if (drv >= 2 && pon != 0) begin
      if (ps > sc) sc = ps;
      if (pa > ac) ac = pa;
      if (pr > rc) rc = pr;
    end
    e.s = sc; e.a = ac; e.r = rc; e.tag = tag;
    return e;
  endfunction

  task automatic check(string tag, bit ok, string what, int got, int want);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, got, want);
    end
  endtask

  // Driver: waits for idle, presents a request, pushes the expected result
  task automatic issue(int s, int a, int c, int p, int rv, int drv,
                       int pon, int ps, int pa, int pr, string tag);
    while (busy) @(negedge clk);
    setup_ns = TW'(s); active_ns = TW'(a); cycle_ns = TW'(c);
    clk_ns = CW'(p); rev = RW'(rv); drive_sel = 2'(drv);
    partner_on = pon[0]; partner_setup = TW'(ps);
    partner_active = CNTW'(pa); partner_recov = CNTW'(pr);
    sb.push_back(model(s, a, c, p, rv, drv, pon, ps, pa, pr, tag));
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic drain();
    int guard = 0;
    while ((sb.size() != 0 || busy) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  // Monitor: compares every result against the head of the scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      if (sb.size() == 0) begin
        check("R9", 1'b0, "unexpected result count", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, setup_cnt == TW'(e.s), "setup_cnt", int'(setup_cnt), e.s);
        check(e.tag, active_cnt == CNTW'(e.a), "active_cnt", int'(active_cnt), e.a);
        check(e.tag, recov_cnt == CNTW'(e.r), "recov_cnt", int'(recov_cnt), e.r);
        last_exp = e;
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, got %0d cycles expected fewer", cyc);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10", busy == 1'b0, "busy", int'(busy), 0);
    check("R10", done == 1'b0, "done", int'(done), 0);
    check("R10", setup_cnt == '0, "setup_cnt", int'(setup_cnt), 0);
    check("R10", active_cnt == '0, "active_cnt", int'(active_cnt), 0);
    check("R10", recov_cnt == '0, "recov_cnt", int'(recov_cnt), 0);

    // R1 ordinary modes at a 30 ns clock
    issue(70, 165, 600, 30, 1, 0, 0, 0, 0, 0, "R1");
    issue(50, 125, 383, 30, 1, 1, 0, 0, 0, 0, "R1");
    issue(30, 80, 180, 30, 0, 0, 0, 0, 0, 0, "R1");
    issue(25, 70, 120, 20, 1, 0, 0, 0, 0, 0, "R1");
    // R2 zero clock period behaves as 1 ns
    issue(3, 2, 9, 0, 1, 0, 0, 0, 0, 0, "R2");
    // R3 setup plus active longer than the cycle, and remainder-dominated case
    issue(200, 300, 100, 30, 1, 0, 0, 0, 0, 0, "R3");
    issue(10, 10, 95, 30, 0, 0, 0, 0, 0, 0, "R3");
    issue(29, 29, 90, 30, 0, 1, 0, 0, 0, 0, "R3");
    // R4 tiny times raised to the minimum
    issue(0, 0, 0, 50, 0, 0, 0, 0, 0, 0, "R4");
    issue(5, 5, 20, 50, 1, 0, 0, 0, 0, 0, "R4");
    // R5 large recovery folded into active, active capped
    issue(70, 165, 1000, 20, 1, 0, 0, 0, 0, 0, "R5");
    issue(10, 40, 1000, 10, 1, 1, 0, 0, 0, 0, "R5");
    issue(10, 500, 900, 1, 0, 0, 0, 0, 0, 0, "R5");
    // R6 revision correction on both sides of the threshold
    issue(70, 165, 600, 30, 2, 0, 0, 0, 0, 0, "R6");
    issue(70, 165, 600, 30, 3, 0, 0, 0, 0, 0, "R6");
    issue(10, 40, 1000, 10, 0, 0, 0, 0, 0, 0, "R6");
    issue(10, 40, 1000, 10, 2, 0, 0, 0, 0, 0, "R6");
    // R7 merge on secondary drives, partner ignored otherwise
    issue(25, 70, 120, 30, 1, 2, 1, 9, 16, 15, "R7");
    issue(25, 70, 120, 30, 1, 3, 1, 1, 2, 2, "R7");
    issue(70, 165, 600, 30, 1, 3, 0, 20, 16, 16, "R7");
    issue(25, 70, 120, 30, 1, 0, 1, 20, 16, 16, "R7");
    issue(25, 70, 120, 30, 1, 1, 1, 20, 16, 16, "R7");
    issue(70, 165, 600, 30, 2, 2, 1, 2, 9, 4, "R7");
    drain();

    // R1 mixed random requests
    for (int i = 0; i < 40; i++) begin
      issue(int'($urandom_range(0, 250)), int'($urandom_range(0, 400)),
            int'($urandom_range(0, 1000)), int'($urandom_range(0, 60)),
            int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
            int'($urandom_range(0, 1)), int'($urandom_range(0, 12)),
            int'($urandom_range(2, 16)), int'($urandom_range(1, 16)), "R1");
    end
    drain();

    // R8 outputs hold long after the pulse
    repeat (20) @(negedge clk);
    check("R8", done == 1'b0, "done after idle", int'(done), 0);
    check("R8", setup_cnt == TW'(last_exp.s), "held setup_cnt", int'(setup_cnt), last_exp.s);
    check("R8", active_cnt == CNTW'(last_exp.a), "held active_cnt", int'(active_cnt), last_exp.a);
    check("R8", recov_cnt == CNTW'(last_exp.r), "held recov_cnt", int'(recov_cnt), last_exp.r);

    // R9 start pulses during a calculation are ignored
    issue(70, 165, 600, 30, 1, 0, 0, 0, 0, 0, "R9");
    check("R9", busy == 1'b1, "busy after start", int'(busy), 1);
    for (int k = 0; k < 5; k++) begin
      setup_ns = TW'(5); active_ns = TW'(5); cycle_ns = TW'(900); clk_ns = CW'(3);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (3) @(negedge clk);
    end
    drain();
    repeat (120) @(negedge clk);
    check("R9", sb.size() == 0, "pending results", sb.size(), 0);
    check("R9", setup_cnt == TW'(3), "setup_cnt after ignored starts", int'(setup_cnt), 3);

    finish_run();
  end
endmodule